// File: doc/BRIEF.md
# Boot Region Remap Address Decoder

This block decodes single-cycle memory requests for a small processor subsystem and routes each one to the on-chip ROM, the first on-chip SRAM (SRAM0) or the second on-chip SRAM (SRAM1). For every request it drives one chip select and a translated local byte offset. It also steers the read data that the selected memory returns one cycle later back to the requester. Requests that match no target are flagged as decode errors.

The lowest 1 MiB of the address map has no storage of its own. It is an alias window that follows a single remap bit. After reset the bit is 0 and the window reads the ROM, so the first fetch at address zero reaches the boot code. Software can set the bit through a small register port, and the window then redirects to SRAM0. Offsets inside the window wrap modulo the size of the selected target. The ROM is read-only at this decoder: a write to it is dropped and reported.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset the remap bit reads 0, and a read at address 0x0 returns the ROM word at ROM offset 0.
- R2: A read in 0x0010_0000..0x0010_7FFF asserts only `rom_cs`, with `mem_off` equal to the address minus 0x0010_0000.
- R3: A request in 0x0020_0000..0x0020_0FFF selects SRAM0 only, and a request in 0x0030_0000..0x0030_0FFF selects SRAM1 only. In both cases `mem_off` holds the low 12 address bits and the byte strobes pass through unchanged.
- R4: When the remap bit is 1, an access to window address N (N < 0x10_0000) reaches SRAM0 offset N. For example, a write to 0x10 is read back at 0x0020_0010.
- R5: Window offsets wrap modulo the target size. With remap 0, address 0x8004 reads ROM offset 0x4. With remap 1, address 0x1008 reaches SRAM0 offset 0x8.
- R6: A write that decodes to the ROM, either directly or through the window, asserts no chip select. It raises `rsp_wrerr` for exactly the one response cycle of that request.
- R7: A request to any other address asserts no chip select. Its response returns `rsp_rdata` = 0 and raises `rsp_decerr` for one cycle. Unmapped addresses include holes inside 0x0..0x0FFF_FFFF and anything above that range.
- R8: A remap value written in cycle T applies to requests issued from cycle T+1 onward. A request issued in cycle T, or one whose response is still pending when the bit changes, keeps the target it decoded to.
- R9: A register read at offset `CTRL_OFF` (default 0) returns the remap bit in bit 0, with all other bits 0. A register read at any other offset returns 0. Writing bit 0 at `CTRL_OFF` sets the bit: 0 means ROM and 1 means SRAM0.
- R10: `rsp_valid` is high exactly one cycle after each cycle with `req_valid` high. No chip select is asserted while `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte strobes |
| reg_en | input | 1 | Register port access |
| reg_we | input | 1 | Register port write |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rom_cs | output | 1 | ROM chip select (reads only) |
| sram0_cs | output | 1 | SRAM0 chip select |
| sram1_cs | output | 1 | SRAM1 chip select |
| mem_we | output | 1 | Write enable to the selected SRAM |
| mem_off | output | 15 | Local byte offset into the selected target |
| mem_wdata | output | 32 | Write data to the SRAMs |
| mem_be | output | 4 | Byte strobes to the SRAMs |
| rom_rdata | input | 32 | ROM read data, one cycle after select |
| sram0_rdata | input | 32 | SRAM0 read data, one cycle after select |
| sram1_rdata | input | 32 | SRAM1 read data, one cycle after select |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Steered read data |
| rsp_decerr | output | 1 | Unmapped-address pulse |
| rsp_wrerr | output | 1 | ROM-write pulse |

## Verification
The hardest case to reach is a remap change that lands while a read response is still pending. The returned word must follow the target the request decoded to, not the new setting. To get there, the bench writes the register port and issues a window read in the same cycle, in both directions. It runs 0-to-1 with a request still decoding against ROM, and 1-to-0 with a request decoding against SRAM0. The memory models hold different patterns, so a wrong steering choice shows up as the other memory's word.

// File: rtl/boot_remap_pkg.sv
// Package: shared target encoding for the boot remap decoder.
// Assumes at most three physical targets plus a "none" code.
package boot_remap_pkg;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_ROM   = 2'd1,
        TGT_SRAM0 = 2'd2,
        TGT_SRAM1 = 2'd3
    } tgt_e;

endpackage

// File: rtl/brd_addr_decode.sv
// Module: brd_addr_decode
// Purely combinational address map. It classifies a byte address into a target
// and a local offset. The boot window aliases ROM or SRAM0 under `remap`, and
// its offset is reduced modulo the chosen target's size.
// Assumes each target base is aligned to its own size and
// the window size is at least as large as every target.
module brd_addr_decode
    import boot_remap_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              BOOT_AW    = 20,
    parameter int              ROM_AW     = 15,
    parameter int              SRAM_AW    = 12,
    parameter int              OFF_W      = 15,
    parameter logic [ADDR_W-1:0] ROM_BASE   = 32'h0010_0000,
    parameter logic [ADDR_W-1:0] SRAM0_BASE = 32'h0020_0000,
    parameter logic [ADDR_W-1:0] SRAM1_BASE = 32'h0030_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              remap,
    output tgt_e              tgt,
    output logic [OFF_W-1:0]  off
);

    logic in_boot, in_rom, in_sram0, in_sram1;

    // Range matches on the bits above each region's size.
    always_comb begin
        in_boot  = (addr[ADDR_W-1:BOOT_AW] == '0);
        in_rom   = (addr[ADDR_W-1:ROM_AW]  == ROM_BASE[ADDR_W-1:ROM_AW]);
        in_sram0 = (addr[ADDR_W-1:SRAM_AW] == SRAM0_BASE[ADDR_W-1:SRAM_AW]);
        in_sram1 = (addr[ADDR_W-1:SRAM_AW] == SRAM1_BASE[ADDR_W-1:SRAM_AW]);
    end

    // Target select and offset translation; window follows the remap bit.
    always_comb begin
        tgt = TGT_NONE;
        off = '0;
        if (in_boot) begin
            if (remap) begin
                tgt = TGT_SRAM0;
                off = OFF_W'(addr[SRAM_AW-1:0]);
            end else begin
                tgt = TGT_ROM;
                off = OFF_W'(addr[ROM_AW-1:0]);
            end
        end else if (in_rom) begin
            tgt = TGT_ROM;
            off = OFF_W'(addr[ROM_AW-1:0]);
        end else if (in_sram0) begin
            tgt = TGT_SRAM0;
            off = OFF_W'(addr[SRAM_AW-1:0]);
        end else if (in_sram1) begin
            tgt = TGT_SRAM1;
            off = OFF_W'(addr[SRAM_AW-1:0]);
        end
    end

endmodule

// File: rtl/brd_ctrl_reg.sv
// Module: brd_ctrl_reg
// Holds the remap control bit behind a tiny register port. It resets to 0,
// which selects ROM. Reads are combinational. Offsets other than CTRL_OFF read
// as zero and ignore writes.
module brd_ctrl_reg #(
    parameter int               DATA_W   = 32,
    parameter int               REG_AW   = 4,
    parameter logic [REG_AW-1:0] CTRL_OFF = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              remap
);

    logic hit;
    logic unused_wdata;

    assign hit          = reg_en && (reg_addr == CTRL_OFF);
    assign unused_wdata = ^reg_wdata[DATA_W-1:1];

    // Remap bit storage; updates at the edge closing the write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap <= 1'b0;
        end else if (hit && reg_we) begin
            remap <= reg_wdata[0];
        end
    end

    // Read mux: only the control offset returns data.
    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            reg_rdata[0] = remap;
        end
    end

endmodule

// File: rtl/brd_rsp_steer.sv
// Module: brd_rsp_steer
// Registers the decoded target of each request and steers the memories'
// next-cycle read data. Because the target is captured, a pending response is
// immune to later remap changes. Also registers the one-cycle error pulses.
// Assumes all memories return read data exactly one cycle after select.
module brd_rsp_steer
    import boot_remap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  tgt_e              tgt,
    input  logic              dec_err,
    input  logic              wr_err,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] sram0_rdata,
    input  logic [DATA_W-1:0] sram1_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_decerr,
    output logic              rsp_wrerr
);

    tgt_e rd_tgt_q;

    // Capture response state: read target (NONE for writes/idle) and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_tgt_q   <= TGT_NONE;
            rsp_valid  <= 1'b0;
            rsp_decerr <= 1'b0;
            rsp_wrerr  <= 1'b0;
        end else begin
            rd_tgt_q   <= (req_valid && !req_write) ? tgt : TGT_NONE;
            rsp_valid  <= req_valid;
            rsp_decerr <= dec_err;
            rsp_wrerr  <= wr_err;
        end
    end

    // Read-data steering by the captured target; zero otherwise.
    always_comb begin
        unique case (rd_tgt_q)
            TGT_ROM:   rsp_rdata = rom_rdata;
            TGT_SRAM0: rsp_rdata = sram0_rdata;
            TGT_SRAM1: rsp_rdata = sram1_rdata;
            default:   rsp_rdata = '0;
        endcase
    end

endmodule

// File: rtl/boot_remap_decoder.sv
// Module: boot_remap_decoder (top)
// Bus-side decoder that maps a boot alias window onto ROM or SRAM0 under a
// software remap bit. It also decodes direct ROM/SRAM0/SRAM1 ranges, blocks ROM
// writes and flags unmapped addresses. Assumes synchronous one-cycle-latency
// memories and one request per cycle with no back-pressure.
module boot_remap_decoder
    import boot_remap_pkg::*;
#(
    parameter int               ADDR_W     = 32,
    parameter int               DATA_W     = 32,
    parameter int               BOOT_AW    = 20,
    parameter int               ROM_AW     = 15,
    parameter int               SRAM_AW    = 12,
    parameter int               REG_AW     = 4,
    parameter logic [REG_AW-1:0] CTRL_OFF  = '0,
    parameter logic [ADDR_W-1:0] ROM_BASE   = 32'h0010_0000,
    parameter logic [ADDR_W-1:0] SRAM0_BASE = 32'h0020_0000,
    parameter logic [ADDR_W-1:0] SRAM1_BASE = 32'h0030_0000,
    localparam int              OFF_W      = (ROM_AW > SRAM_AW) ? ROM_AW : SRAM_AW,
    localparam int              BE_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              rom_cs,
    output logic              sram0_cs,
    output logic              sram1_cs,
    output logic              mem_we,
    output logic [OFF_W-1:0]  mem_off,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] sram0_rdata,
    input  logic [DATA_W-1:0] sram1_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_decerr,
    output logic              rsp_wrerr
);

    logic remap;
    tgt_e tgt;
    logic dec_err;
    logic wr_err;

    brd_ctrl_reg #(
        .DATA_W   (DATA_W),
        .REG_AW   (REG_AW),
        .CTRL_OFF (CTRL_OFF)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .remap     (remap)
    );

    brd_addr_decode #(
        .ADDR_W     (ADDR_W),
        .BOOT_AW    (BOOT_AW),
        .ROM_AW     (ROM_AW),
        .SRAM_AW    (SRAM_AW),
        .OFF_W      (OFF_W),
        .ROM_BASE   (ROM_BASE),
        .SRAM0_BASE (SRAM0_BASE),
        .SRAM1_BASE (SRAM1_BASE)
    ) u_dec (
        .addr  (req_addr),
        .remap (remap),
        .tgt   (tgt),
        .off   (mem_off)
    );

    // Chip selects, write enable and error detection for the current request.
    always_comb begin
        rom_cs   = req_valid && (tgt == TGT_ROM) && !req_write;
        sram0_cs = req_valid && (tgt == TGT_SRAM0);
        sram1_cs = req_valid && (tgt == TGT_SRAM1);
        mem_we   = req_write && (sram0_cs || sram1_cs);
        wr_err   = req_valid && req_write && (tgt == TGT_ROM);
        dec_err  = req_valid && (tgt == TGT_NONE);
    end

    assign mem_wdata = req_wdata;
    assign mem_be    = req_be;

    brd_rsp_steer #(
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .tgt         (tgt),
        .dec_err     (dec_err),
        .wr_err      (wr_err),
        .rom_rdata   (rom_rdata),
        .sram0_rdata (sram0_rdata),
        .sram1_rdata (sram1_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .rsp_decerr  (rsp_decerr),
        .rsp_wrerr   (rsp_wrerr)
    );

endmodule

// File: rtl/boot_remap_decoder_chk.sv
// Module: boot_remap_decoder_chk
// Port-level protocol checks for boot_remap_decoder, attached with bind.
module boot_remap_decoder_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              rom_cs,
    input logic              sram0_cs,
    input logic              sram1_cs,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_decerr,
    input logic              rsp_wrerr
);

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R10
    no_cs_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(rom_cs || sram0_cs || sram1_cs));

    // R3
    single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs, sram0_cs, sram1_cs}));

    // R6
    rom_never_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> !req_write);

    // R6
    dropped_write_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !sram0_cs && !sram1_cs) |=> (rsp_wrerr || rsp_decerr));

    // R7
    decerr_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_decerr |-> (rsp_rdata == '0));

    // R7
    decerr_had_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_decerr |-> $past(req_valid && !rom_cs && !sram0_cs && !sram1_cs));

endmodule

bind boot_remap_decoder boot_remap_decoder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/boot_remap_decoder_tb.sv
// Directed bench for boot_remap_decoder with behavioural one-cycle memories.
module boot_remap_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rom_cs, sram0_cs, sram1_cs, mem_we;
    logic [14:0] mem_off;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] rom_rdata = '0, sram0_rdata = '0, sram1_rdata = '0;
    logic        rsp_valid, rsp_decerr, rsp_wrerr;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] sram0_mem [1024];
    logic [31:0] sram1_mem [1024];

    always #10 clk = ~clk;

    boot_remap_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .req_be(req_be),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rom_cs(rom_cs), .sram0_cs(sram0_cs), .sram1_cs(sram1_cs),
        .mem_we(mem_we), .mem_off(mem_off), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .rom_rdata(rom_rdata), .sram0_rdata(sram0_rdata), .sram1_rdata(sram1_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_decerr(rsp_decerr), .rsp_wrerr(rsp_wrerr)
    );

    // Memory models: ROM word = 0xC0DE_0000 | byte offset; SRAMs are arrays.
    always @(posedge clk) begin
        if (rom_cs) rom_rdata <= 32'hC0DE_0000 | 32'(mem_off);
        if (sram0_cs) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) sram0_mem[mem_off[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else sram0_rdata <= sram0_mem[mem_off[11:2]];
        end
        if (sram1_cs) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) sram1_mem[mem_off[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else sram1_rdata <= sram1_mem[mem_off[11:2]];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request for one cycle; returns at the following negedge (response visible).
    task automatic issue(input logic [31:0] a, input logic w, input logic [31:0] d,
                         input logic [3:0] be, output logic [2:0] cs);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d; req_be = be;
        #1 cs = {rom_cs, sram0_cs, sram1_cs};
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic set_remap(input logic v);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = {31'h0, v};
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic t_reset;
        logic [2:0] cs;
        reg_en = 1'b1; reg_addr = 4'h0; #1;
        check("R1 remap reset", reg_rdata, 32'h0);
        reg_en = 1'b0;
        check("R10 no cs idle", {29'h0, rom_cs, sram0_cs, sram1_cs}, 32'h0);
        issue(32'h0, 1'b0, '0, 4'hF, cs);
        check("R1 boot->ROM cs", {29'h0, cs}, 32'h4);
        check("R1 boot read", rsp_rdata, 32'hC0DE_0000);
        check("R10 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        @(negedge clk);
        check("R10 rsp_valid drop", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_direct;
        logic [2:0] cs;
        issue(32'h0010_7FFC, 1'b0, '0, 4'hF, cs);
        check("R2 rom cs", {29'h0, cs}, 32'h4);
        check("R2 rom data", rsp_rdata, 32'hC0DE_7FFC);
        issue(32'h0020_0FFC, 1'b0, '0, 4'hF, cs);
        check("R3 sram0 cs", {29'h0, cs}, 32'h2);
        check("R3 sram0 data", rsp_rdata, 32'h5A00_03FF);
        issue(32'h0030_0008, 1'b0, '0, 4'hF, cs);
        check("R3 sram1 cs", {29'h0, cs}, 32'h1);
        check("R3 sram1 data", rsp_rdata, 32'hB100_0002);
        issue(32'h0020_0014, 1'b1, 32'h1122_33AA, 4'b0001, cs);
        issue(32'h0020_0014, 1'b0, '0, 4'hF, cs);
        check("R3 byte strobe", rsp_rdata, 32'h5A00_00AA);
    endtask

    task automatic t_alias;
        logic [2:0] cs;
        issue(32'h0000_8004, 1'b0, '0, 4'hF, cs);
        check("R5 rom wrap", rsp_rdata, 32'hC0DE_0004);
        set_remap(1'b1);
        reg_en = 1'b1; reg_addr = 4'h0; #1;
        check("R9 remap read", reg_rdata, 32'h1);
        reg_addr = 4'h3; #1;
        check("R9 other offset", reg_rdata, 32'h0);
        reg_en = 1'b0;
        issue(32'h0000_0010, 1'b1, 32'hDEAD_BEEF, 4'hF, cs);
        check("R4 alias write cs", {29'h0, cs}, 32'h2);
        issue(32'h0020_0010, 1'b0, '0, 4'hF, cs);
        check("R4 alias readback", rsp_rdata, 32'hDEAD_BEEF);
        issue(32'h0000_1008, 1'b0, '0, 4'hF, cs);
        check("R5 sram0 wrap", rsp_rdata, 32'h5A00_0002);
        set_remap(1'b0);
    endtask

    task automatic t_rom_write;
        logic [2:0] cs;
        issue(32'h0010_0004, 1'b1, 32'h1234_5678, 4'hF, cs);
        check("R6 direct rom write no cs", {29'h0, cs}, 32'h0);
        check("R6 wrerr", {31'h0, rsp_wrerr}, 32'h1);
        @(negedge clk);
        check("R6 wrerr one cycle", {31'h0, rsp_wrerr}, 32'h0);
        issue(32'h0000_0004, 1'b1, 32'h1234_5678, 4'hF, cs);
        check("R6 window rom write no cs", {29'h0, cs}, 32'h0);
        check("R6 window wrerr", {31'h0, rsp_wrerr}, 32'h1);
    endtask

    task automatic t_unmapped;
        logic [2:0] cs;
        issue(32'h0010_8000, 1'b0, '0, 4'hF, cs);
        check("R7 past rom no cs", {29'h0, cs}, 32'h0);
        check("R7 decerr", {31'h0, rsp_decerr}, 32'h1);
        check("R7 zero data", rsp_rdata, 32'h0);
        issue(32'h0050_0000, 1'b0, '0, 4'hF, cs);
        check("R7 hole decerr", {31'h0, rsp_decerr}, 32'h1);
        issue(32'h1000_0000, 1'b0, '0, 4'hF, cs);
        check("R7 above region decerr", {31'h0, rsp_decerr}, 32'h1);
        @(negedge clk);
        check("R7 decerr one cycle", {31'h0, rsp_decerr}, 32'h0);
    endtask

    task automatic t_remap_timing;
        // Remap write and window read in the same cycle: read keeps ROM.
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h1;
        req_valid = 1'b1; req_addr = 32'h0; req_write = 1'b0;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        check("R8 same-cycle old target", rsp_rdata, 32'hC0DE_0000);
        // Next-cycle request sees SRAM0; issue it together with remap back to 0.
        reg_en = 1'b1; reg_we = 1'b1; reg_wdata = 32'h0;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; req_valid = 1'b0;
        check("R8 in-flight keeps SRAM0", rsp_rdata, 32'h5A00_0000);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 new value applies", rsp_rdata, 32'hC0DE_0000);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            sram0_mem[i] = 32'h5A00_0000 | i;
            sram1_mem[i] = 32'hB100_0000 | i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_alias();
        t_rom_write();
        t_unmapped();
        t_remap_timing();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule